// File: doc/BRIEF.md
# Operand Shifter with Status Flags

This block shifts an 8, 16 or 32-bit operand left or right by a count and reports the status flags an integer datapath needs after a shift: carry, overflow, sign, zero and parity. It samples its inputs on every rising clock edge. One cycle later it presents the result and the flags, together with a flag-write strobe that tells the surrounding flag register whether to take the new flag values.

Three shift kinds are supported. The first is a left shift with zero fill, which also serves as the arithmetic left shift. The second is a right shift with zero fill. The third is a right shift that replicates the sign bit, so a negative value is divided by a power of two and rounded toward negative infinity. Only the low five bits of the count are used. When those five bits are zero, the operand passes through unchanged and the flag-write strobe stays low, so the existing flags survive.

Top module: `shift_flags_unit`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: Only `cnt_i[4:0]` is used. Bits 7:5 of the count have no effect on any output.
- R3: For `op_i` 2'b00 and 2'b11, the result is the sized operand shifted left by the count, with zeros entering at bit 0. The two codes give identical outputs.
- R4: For `op_i` 2'b01, the result is the sized operand shifted right by the count, with zeros entering at the top bit of the selected size.
- R5: For `op_i` 2'b10, the vacated top bits take the operand's original sign bit, so an odd negative value rounds toward negative infinity (for example, byte 8'hFB shifted by 1 gives 8'hFD).
- R6: `cf_o` holds the last bit shifted out. If a left shift count exceeds the size, this bit is 0. If a zero-fill right shift count exceeds the size, it is 0. If a sign-fill right shift count exceeds the size, it is the sign bit.
- R7: For a left shift by exactly 1, `of_o` is 1 when the result's top bit differs from the operand's top bit, and 0 otherwise. For every other count and for every right shift, `of_o` is 0.
- R8: `sf_o` is the top bit of the sized result. `zf_o` is 1 when the sized result is zero. `pf_o` is 1 when `res_o[7:0]` has an even number of ones.
- R9: When `cnt_i[4:0]` is 0, `res_o` equals the sized operand, all five flags are 0, and `flag_we_o` is 0. Otherwise `flag_we_o` is 1.
- R10: `size_i` 2'b00 selects 8 bits, 2'b01 selects 16 bits, and 2'b10 and 2'b11 select 32 bits. Operand bits above the selected size are ignored, and result bits above it are 0.
- R11: Outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_i | input | 32 | Operand (low bits used per size) |
| cnt_i | input | 8 | Shift count (low five bits used) |
| op_i | input | 2 | 00/11 left, 01 right zero fill, 10 right sign fill |
| size_i | input | 2 | 00 byte, 01 half, 10/11 full 32 bits |
| res_o | output | 32 | Shifted result, zero above the size |
| cf_o | output | 1 | Last bit shifted out |
| of_o | output | 1 | Sign change on single-bit left shift |
| sf_o | output | 1 | Top bit of sized result |
| zf_o | output | 1 | Sized result is zero |
| pf_o | output | 1 | Even parity of the result's low byte |
| flag_we_o | output | 1 | Flags are to be written |

## Verification
Some properties are checked on every cycle by the assertions. The flag-write strobe must follow the masked count, and a zero count must leave all flags clear. Overflow must stay low unless the count was one. The zero flag must agree with the result, and byte-sized results must stay clear above bit 7. The shifted values themselves are only shown by the bench's scenarios: sign-fill rounding, carry for counts beyond the operand size, the sign-change overflow rule, parity and the ignored high count bits. The bench compares each of these against a bit-by-bit reference model.

// File: rtl/shift_flags_unit.sv
module shift_flags_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] opnd_i,
  input  logic [7:0]  cnt_i,
  input  logic [1:0]  op_i,
  input  logic [1:0]  size_i,
  output logic [31:0] res_o,
  output logic        cf_o,
  output logic        of_o,
  output logic        sf_o,
  output logic        zf_o,
  output logic        pf_o,
  output logic        flag_we_o
);

  logic [4:0]  n;
  logic [31:0] a;
  logic        top_in;
  logic [6:0]  width;
  logic        is_right, fill;
  logic [63:0] lsh, sext;
  logic [64:0] rsh;
  logic [31:0] res_n;
  logic        cf_n, top_out;

  assign n        = cnt_i[4:0];
  assign is_right = (op_i == 2'b01) || (op_i == 2'b10);
  assign fill     = (op_i == 2'b10) && top_in;

  always_comb begin
    case (size_i)
      2'b00:   begin a = {24'b0, opnd_i[7:0]};  top_in = opnd_i[7];  width = 7'd8;  end
      2'b01:   begin a = {16'b0, opnd_i[15:0]}; top_in = opnd_i[15]; width = 7'd16; end
      default: begin a = opnd_i;                top_in = opnd_i[31]; width = 7'd32; end
    endcase
  end

  assign sext = {32'b0, a} | ({64{fill}} << width);
  assign lsh  = {32'b0, a} << n;
  assign rsh  = {sext, 1'b0} >> n;

  always_comb begin
    case (size_i)
      2'b00: begin
        res_n   = is_right ? {24'b0, rsh[8:1]} : {24'b0, lsh[7:0]};
        cf_n    = is_right ? rsh[0] : lsh[8];
        top_out = res_n[7];
      end
      2'b01: begin
        res_n   = is_right ? {16'b0, rsh[16:1]} : {16'b0, lsh[15:0]};
        cf_n    = is_right ? rsh[0] : lsh[16];
        top_out = res_n[15];
      end
      default: begin
        res_n   = is_right ? rsh[32:1] : lsh[31:0];
        cf_n    = is_right ? rsh[0] : lsh[32];
        top_out = res_n[31];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o     <= '0;
      cf_o      <= 1'b0;
      of_o      <= 1'b0;
      sf_o      <= 1'b0;
      zf_o      <= 1'b0;
      pf_o      <= 1'b0;
      flag_we_o <= 1'b0;
    end else if (n == 5'd0) begin
      res_o     <= a;
      cf_o      <= 1'b0;
      of_o      <= 1'b0;
      sf_o      <= 1'b0;
      zf_o      <= 1'b0;
      pf_o      <= 1'b0;
      flag_we_o <= 1'b0;
    end else begin
      res_o     <= res_n;
      cf_o      <= cf_n;
      of_o      <= !is_right && (n == 5'd1) && (top_out != top_in);
      sf_o      <= top_out;
      zf_o      <= (res_n == 32'b0);
      pf_o      <= ~^res_n[7:0];
      flag_we_o <= 1'b1;
    end
  end

endmodule

// File: rtl/shift_flags_unit_chk.sv
module shift_flags_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  cnt_i,
  input logic [1:0]  op_i,
  input logic [1:0]  size_i,
  input logic [31:0] res_o,
  input logic        cf_o,
  input logic        of_o,
  input logic        sf_o,
  input logic        zf_o,
  input logic        pf_o,
  input logic        flag_we_o
);

  logic primed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;

  AST_WE_FOLLOWS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (flag_we_o == ($past(cnt_i[4:0]) != 5'd0))); // R9

  AST_IDLE_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we_o |-> !(cf_o || of_o || sf_o || zf_o || pf_o)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(cnt_i[4:0]) != 5'd1) |-> !of_o); // R7

  AST_RIGHT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && ($past(op_i) == 2'b01 || $past(op_i) == 2'b10)) |-> !of_o); // R7

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_o |-> (zf_o == (res_o == 32'b0))); // R8

  AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(size_i) == 2'b00) |-> (res_o[31:8] == 24'b0)); // R10

endmodule

bind shift_flags_unit shift_flags_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .op_i(op_i), .size_i(size_i),
  .res_o(res_o), .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o), .zf_o(zf_o),
  .pf_o(pf_o), .flag_we_o(flag_we_o)
);

// File: tb/shift_flags_unit_tb_top.sv
module shift_flags_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_i = '0;
  logic [7:0]  cnt_i = '0;
  logic [1:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] res_o;
  logic        cf_o, of_o, sf_o, zf_o, pf_o, flag_we_o;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  shift_flags_unit dut_i (
    .clk(clk), .rst_n(rst_n), .opnd_i(opnd_i), .cnt_i(cnt_i), .op_i(op_i),
    .size_i(size_i), .res_o(res_o), .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o),
    .zf_o(zf_o), .pf_o(pf_o), .flag_we_o(flag_we_o)
  );

  // packed expectation: {we, pf, zf, sf, of, cf, res[31:0]}
  function automatic logic [37:0] model(input logic [31:0] x, input logic [7:0] c,
                                        input logic [1:0] op, input logic [1:0] sz);
    int w;
    logic [31:0] v, orig;
    logic carry, ovf;
    int n;
    w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    v = 32'b0;
    for (int i = 0; i < w; i++) v[i] = x[i];
    orig = v;
    n = int'(c[4:0]);
    if (n == 0) return {6'b0, v};
    carry = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (op == 2'b01 || op == 2'b10) begin
        carry = v[0];
        v = v >> 1;
        if (op == 2'b10) v[w-1] = orig[w-1];
      end else begin
        carry = v[w-1];
        v = v << 1;
        v[w] = 1'b0;
        if (w < 32) for (int i = w; i < 32; i++) v[i] = 1'b0;
      end
    end
    ovf = (op == 2'b00 || op == 2'b11) && n == 1 && (v[w-1] != orig[w-1]);
    return {1'b1, ~^v[7:0], v == 32'b0, v[w-1], ovf, carry, v};
  endfunction

  task automatic check(input string tag, input logic [37:0] exp);
    logic [37:0] act;
    act = {flag_we_o, pf_o, zf_o, sf_o, of_o, cf_o, res_o};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual={we,pf,zf,sf,of,cf,res}=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] x, input logic [7:0] c,
                     input logic [1:0] op, input logic [1:0] sz);
    @(negedge clk);
    opnd_i = x; cnt_i = c; op_i = op; size_i = sz;
    @(negedge clk);
    check(tag, model(x, c, op, sz));
  endtask

  task automatic finish_run;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 50000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [37:0] e1, e2;
    void'($urandom(32'd20240531));
    opnd_i = 32'hFFFF_FFFF; cnt_i = 8'h05;
    repeat (3) @(negedge clk);
    check("R1 reset", 38'b0);
    rst_n = 1'b1;

    // R3 / R7: hand-computed byte left shifts by one
    run("R7 shl 81", 32'h81, 8'd1, 2'b00, 2'b00);
    check("R7 shl 81 fixed", {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h02});
    run("R7 shl 40", 32'h40, 8'd1, 2'b00, 2'b00);
    run("R7 shl C0", 32'hC0, 8'd1, 2'b00, 2'b00);
    run("R3 sal code", 32'h1234_5678, 8'd7, 2'b11, 2'b10);
    run("R3 shl code", 32'h1234_5678, 8'd7, 2'b00, 2'b10);
    run("R4 shr half", 32'hFFFF_8001, 8'd1, 2'b01, 2'b01);
    run("R5 sar round", 32'hFB, 8'd1, 2'b10, 2'b00);
    check("R5 sar FB fixed", {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'hFD});
    run("R5 sar dword neg", 32'h8000_0003, 8'd4, 2'b10, 2'b10);
    run("R6 shl byte cnt8", 32'h01, 8'd8, 2'b00, 2'b00);
    run("R6 shl byte cnt9", 32'hFF, 8'd9, 2'b00, 2'b00);
    run("R6 sar byte cnt20", 32'h80, 8'd20, 2'b10, 2'b00);
    check("R6 sar beyond fixed", {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'hFF});
    run("R6 shr byte cnt20", 32'h80, 8'd20, 2'b01, 2'b00);
    run("R6 shr dword cnt31", 32'h8000_0000, 8'd31, 2'b01, 2'b10);
    run("R2 count mask 21", 32'h0000_00A5, 8'h21, 2'b00, 2'b00);
    run("R9 zero count", 32'hDEAD_BEEF, 8'h00, 2'b10, 2'b01);
    check("R9 zero count fixed", {6'b0, 32'h0000_BEEF});
    run("R9 masked zero", 32'hDEAD_BEEF, 8'hE0, 2'b01, 2'b11);
    run("R10 size 11", 32'hF000_000F, 8'd3, 2'b10, 2'b11);
    run("R10 byte upper ignored", 32'hABCD_EF01, 8'd2, 2'b01, 2'b00);
    run("R8 zero result", 32'h0000_0100, 8'd1, 2'b00, 2'b00);

    // R2: high count bits change nothing
    for (int i = 0; i < 20; i++) begin
      logic [31:0] x;
      logic [4:0] c;
      logic [1:0] op, sz;
      x = $urandom; c = 5'($urandom); op = 2'($urandom); sz = 2'($urandom);
      run("R2 base", x, {3'b000, c}, op, sz);
      e1 = {flag_we_o, pf_o, zf_o, sf_o, of_o, cf_o, res_o};
      run("R2 high bits", x, {3'($urandom), c}, op, sz);
      e2 = {flag_we_o, pf_o, zf_o, sf_o, of_o, cf_o, res_o};
      checks++;
      if (e1 !== e2) begin
        fails++;
        $display("FAIL R2 high count bits actual=%h expected=%h", e2, e1);
      end
    end

    // R3 R4 R5 R6 R7 R8 R10 R11: random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] c;
      c = (i % 4 == 0) ? 8'd1 : 8'($urandom);
      run("R3/R4/R5/R6/R7/R8/R10/R11 random", $urandom, c, 2'($urandom), 2'($urandom));
    end

    finish_run();
  end
endmodule